// File: doc/BRIEF.md
# EDID Image Read Overlay

This block forms the byte stream that a sink port hands to a source when the source reads the 512-byte EDID image over the display data channel. The image is four 128-byte blocks. Each block ends in its checksum byte. Most bytes come straight from an internal EDID RAM. Three bytes are different. Two bytes at a programmable location carry the port's 16-bit source physical address. The checksum byte of the block that holds that location carries a per-port checksum. All three values come from per-port configuration inputs.

The block drives the RAM address straight from the read address. It takes the RAM byte back in the same cycle, so it assumes a RAM with an asynchronous read port. It registers the selected byte, so the RAM lookup and the overlay selection form one pipeline stage. A read is requested by pulsing a strobe with the address. The byte and a valid flag appear on the clock edge after the strobe is sampled. When the port's EDID enable is low, the port behaves as an absent EDID: the valid flag stays low and the data reads as all ones.

Top module: `edid_read_overlay`

## Requirements
- R1: After reset, `rd_valid` is 0 and `rd_data` is 0xFF.
- R2: A read strobe sampled on a clock edge sets `rd_valid` to the enable value on that same edge. On an edge where the strobe is low, `rd_valid` is 0 afterwards. Back-to-back strobes each deliver their own byte on consecutive cycles.
- R3: With the enable at 1, a byte that is not one of the three substituted addresses reads as the RAM byte at that address.
- R4: With the enable at 1, a read at the programmed location returns bits [15:8] of the physical-address value.
- R5: With the enable at 1, a read at location+1 returns bits [7:0] of the physical-address value. Location+1 wraps modulo 512, so location 0x1FF puts the low byte at 0x000.
- R6: With the enable at 1, a read at the address with bits [8:7] equal to location bits [8:7] and bits [6:0] all ones returns the programmed port checksum.
- R7: The checksum bytes of the three blocks that do not hold the location (0x07F, 0x0FF, 0x17F, 0x1FF, less the substituted one) read as RAM bytes.
- R8: With the enable at 0, a strobed read yields `rd_valid` = 0 and `rd_data` = 0xFF for any address.
- R9: If location or location+1 falls on the substituted checksum byte, that address returns the port checksum. The checksum takes priority.
- R10: On a clock edge without a strobe, `rd_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovl_en | input | 1 | Port EDID enable; 0 makes the port appear absent |
| pa_loc | input | 9 | Byte address of the physical-address high byte |
| pa_value | input | 16 | Source physical address to insert |
| port_csum | input | 8 | Checksum for the block holding `pa_loc` |
| rd_strobe | input | 1 | Read request, sampled on the rising edge |
| rd_addr | input | 9 | Byte address of the read |
| ram_addr | output | 9 | Address driven to the EDID RAM |
| ram_data | input | 8 | Asynchronous read data from the EDID RAM |
| rd_data | output | 8 | Image byte returned to the read port |
| rd_valid | output | 1 | Byte on `rd_data` belongs to a read just served |

## Verification
Every result is due exactly one rising edge after the strobe is sampled. This covers the substituted byte, the RAM byte, the disabled 0xFF pattern and the valid flag. The bench drives inputs on the falling edge, lets one rising edge pass and samples on the next falling edge. Back-to-back reads are checked at each falling edge in turn, so each result is taken from the cycle it belongs to. Hold behaviour is checked after idle edges, by comparing against the byte captured earlier.

// File: rtl/edid_ovl_pkg.sv
package edid_ovl_pkg;

  localparam int EDID_AW  = 9;
  localparam int BLK_OFSW = 7;
  localparam int EDID_DW  = 8;

  typedef enum logic [1:0] {
    SRC_RAM   = 2'd0,
    SRC_PA_HI = 2'd1,
    SRC_PA_LO = 2'd2,
    SRC_CSUM  = 2'd3
  } src_sel_e;

  // Address of the low physical-address byte, wrapping over the image.
  function automatic logic [EDID_AW-1:0] pa_lo_addr(input logic [EDID_AW-1:0] loc);
    return loc + EDID_AW'(1);
  endfunction

  // Checksum byte of the block that contains loc.
  function automatic logic [EDID_AW-1:0] csum_addr(input logic [EDID_AW-1:0] loc);
    return {loc[EDID_AW-1:BLK_OFSW], {BLK_OFSW{1'b1}}};
  endfunction

endpackage

// File: rtl/edid_ovl_decode.sv
module edid_ovl_decode
  import edid_ovl_pkg::*;
#(
  parameter int AW   = EDID_AW,
  parameter int OFSW = BLK_OFSW
) (
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] pa_loc,
  output src_sel_e      sel,
  output logic          hit_csum,
  output logic          hit_hi,
  output logic          hit_lo
);

  localparam int BLKW = AW - OFSW;

  logic [BLKW-1:0] addr_blk, loc_blk;
  logic            addr_last;

  assign addr_blk  = rd_addr[AW-1:OFSW];
  assign loc_blk   = pa_loc[AW-1:OFSW];
  assign addr_last = &rd_addr[OFSW-1:0];

  assign hit_csum = addr_last && (addr_blk == loc_blk);
  assign hit_hi   = (rd_addr == pa_loc);
  assign hit_lo   = (rd_addr == AW'(pa_loc + AW'(1)));

  // The checksum wins over both address bytes.
  always_comb begin
    if (hit_csum)      sel = SRC_CSUM;
    else if (hit_hi)   sel = SRC_PA_HI;
    else if (hit_lo)   sel = SRC_PA_LO;
    else               sel = SRC_RAM;
  end

endmodule

// File: rtl/edid_ovl_mux.sv
module edid_ovl_mux
  import edid_ovl_pkg::*;
#(
  parameter int DW = EDID_DW
) (
  input  src_sel_e        sel,
  input  logic [DW-1:0]   ram_data,
  input  logic [2*DW-1:0] pa_value,
  input  logic [DW-1:0]   port_csum,
  output logic [DW-1:0]   byte_out
);

  always_comb begin
    unique case (sel)
      SRC_PA_HI: byte_out = pa_value[2*DW-1:DW];
      SRC_PA_LO: byte_out = pa_value[DW-1:0];
      SRC_CSUM:  byte_out = port_csum;
      default:   byte_out = ram_data;
    endcase
  end

endmodule

// File: rtl/edid_ovl_outreg.sv
module edid_ovl_outreg
  import edid_ovl_pkg::*;
#(
  parameter int DW = EDID_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_strobe,
  input  logic          ovl_en,
  input  logic [DW-1:0] byte_in,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  localparam logic [DW-1:0] IDLE_BYTE = {DW{1'b1}};

  logic take_byte;
  assign take_byte = rd_strobe && ovl_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= IDLE_BYTE;
    end else begin
      rd_valid <= take_byte;
      if (rd_strobe) rd_data <= ovl_en ? byte_in : IDLE_BYTE;
    end
  end

  // R8
  dis_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !ovl_en) |=> (!rd_valid && rd_data == IDLE_BYTE));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rd_valid == $past(rd_strobe && ovl_en)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(rd_data));

endmodule

// File: rtl/edid_read_overlay.sv
module edid_read_overlay
  import edid_ovl_pkg::*;
#(
  parameter int AW   = EDID_AW,
  parameter int OFSW = BLK_OFSW,
  parameter int DW   = EDID_DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ovl_en,
  input  logic [AW-1:0]   pa_loc,
  input  logic [2*DW-1:0] pa_value,
  input  logic [DW-1:0]   port_csum,
  input  logic            rd_strobe,
  input  logic [AW-1:0]   rd_addr,
  output logic [AW-1:0]   ram_addr,
  input  logic [DW-1:0]   ram_data,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid
);

  src_sel_e      sel;
  logic          hit_csum, hit_hi, hit_lo;
  logic [DW-1:0] ovl_byte;

  assign ram_addr = rd_addr;

  edid_ovl_decode #(.AW(AW), .OFSW(OFSW)) u_decode (
    .rd_addr  (rd_addr),
    .pa_loc   (pa_loc),
    .sel      (sel),
    .hit_csum (hit_csum),
    .hit_hi   (hit_hi),
    .hit_lo   (hit_lo)
  );

  edid_ovl_mux #(.DW(DW)) u_mux (
    .sel       (sel),
    .ram_data  (ram_data),
    .pa_value  (pa_value),
    .port_csum (port_csum),
    .byte_out  (ovl_byte)
  );

  edid_ovl_outreg #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_strobe (rd_strobe),
    .ovl_en    (ovl_en),
    .byte_in   (ovl_byte),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  logic rd_live;
  assign rd_live = rd_strobe && ovl_en;

  // R6 R9
  csum_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_live && rd_addr == csum_addr(pa_loc)) |=> (rd_data == $past(port_csum)));

  // R4
  pa_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_live && rd_addr == pa_loc && rd_addr != csum_addr(pa_loc))
      |=> (rd_data == $past(pa_value[2*DW-1:DW])));

  // R5
  pa_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_live && rd_addr == pa_lo_addr(pa_loc) && rd_addr != csum_addr(pa_loc))
      |=> (rd_data == $past(pa_value[DW-1:0])));

  // R3 R7
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_live && rd_addr != pa_loc && rd_addr != pa_lo_addr(pa_loc)
             && rd_addr != csum_addr(pa_loc))
      |=> (rd_data == $past(ram_data)));

endmodule

// File: tb/tb_edid_read_overlay.sv
module tb_edid_read_overlay;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ovl_en = 1'b0;
  logic [8:0]  pa_loc = '0;
  logic [15:0] pa_value = '0;
  logic [7:0]  port_csum = '0;
  logic        rd_strobe = 1'b0;
  logic [8:0]  rd_addr = '0;
  logic [8:0]  ram_addr;
  logic [7:0]  ram_data;
  logic [7:0]  rd_data;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // RAM model with asynchronous read
  function automatic logic [7:0] ram_byte(input logic [8:0] a);
    return a[7:0] ^ {a[8], 7'h35};
  endfunction
  assign ram_data = ram_byte(ram_addr);

  edid_read_overlay dut (
    .clk(clk), .rst_n(rst_n), .ovl_en(ovl_en), .pa_loc(pa_loc),
    .pa_value(pa_value), .port_csum(port_csum), .rd_strobe(rd_strobe),
    .rd_addr(rd_addr), .ram_addr(ram_addr), .ram_data(ram_data),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // {en, loc, pa, csum, addr, use_ram, expected byte, requirement number}
  localparam logic [55:0] VECS [NVEC] = '{
    {1'b1, 9'h0A3, 16'h1234, 8'h5A, 9'h0A3, 1'b0, 8'h12, 4'd4},  // R4
    {1'b1, 9'h0A3, 16'h1234, 8'h5A, 9'h0A4, 1'b0, 8'h34, 4'd5},  // R5
    {1'b1, 9'h0A3, 16'h1234, 8'h5A, 9'h0A2, 1'b1, 8'h00, 4'd3},  // R3
    {1'b1, 9'h0A3, 16'h1234, 8'h5A, 9'h0A5, 1'b1, 8'h00, 4'd3},
    {1'b1, 9'h0A3, 16'h1234, 8'h5A, 9'h0FF, 1'b0, 8'h5A, 4'd6},  // R6
    {1'b1, 9'h0A3, 16'h1234, 8'h5A, 9'h07F, 1'b1, 8'h00, 4'd7},  // R7
    {1'b1, 9'h0A3, 16'h1234, 8'h5A, 9'h17F, 1'b1, 8'h00, 4'd7},
    {1'b1, 9'h0A3, 16'h1234, 8'h5A, 9'h1FF, 1'b1, 8'h00, 4'd7},
    {1'b1, 9'h1C0, 16'hBEEF, 8'hC3, 9'h1C0, 1'b0, 8'hBE, 4'd4},
    {1'b1, 9'h1C0, 16'hBEEF, 8'hC3, 9'h1C1, 1'b0, 8'hEF, 4'd5},
    {1'b1, 9'h1C0, 16'hBEEF, 8'hC3, 9'h1FF, 1'b0, 8'hC3, 4'd6},
    {1'b1, 9'h1C0, 16'hBEEF, 8'hC3, 9'h0FF, 1'b1, 8'h00, 4'd7},
    {1'b1, 9'h1C0, 16'hBEEF, 8'hC3, 9'h0C0, 1'b1, 8'h00, 4'd3},
    {1'b1, 9'h17E, 16'hA1B2, 8'h77, 9'h17E, 1'b0, 8'hA1, 4'd4},
    {1'b1, 9'h17E, 16'hA1B2, 8'h77, 9'h17F, 1'b0, 8'h77, 4'd9},  // R9 low byte clash
    {1'b1, 9'h17E, 16'hA1B2, 8'h77, 9'h180, 1'b1, 8'h00, 4'd3},
    {1'b1, 9'h1FF, 16'h4455, 8'h99, 9'h1FF, 1'b0, 8'h99, 4'd9},  // R9 high byte clash
    {1'b1, 9'h1FF, 16'h4455, 8'h99, 9'h000, 1'b0, 8'h55, 4'd5},  // R5 wrap
    {1'b0, 9'h0A3, 16'h1234, 8'h5A, 9'h0A3, 1'b0, 8'hFF, 4'd8},  // R8
    {1'b0, 9'h0A3, 16'h1234, 8'h5A, 9'h150, 1'b0, 8'hFF, 4'd8}
  };

  task automatic check(input string req, input logic ok,
                       input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_cfg(input logic en, input logic [8:0] loc,
                         input logic [15:0] pa, input logic [7:0] cs);
    ovl_en = en; pa_loc = loc; pa_value = pa; port_csum = cs;
  endtask

  // Strobe in one cycle, sample at the falling edge after the capturing edge.
  task automatic read_one(input logic [8:0] a);
    @(negedge clk);
    rd_addr = a; rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", rd_valid == 1'b0 && rd_data == 8'hFF, {rd_valid, rd_data}, 9'h0FF);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [55:0] v;
      logic [7:0] exp;
      v = VECS[i];
      set_cfg(v[55], v[54:46], v[45:30], v[29:22]);
      read_one(v[21:13]);
      exp = v[12] ? ram_byte(v[21:13]) : v[11:4];
      check($sformatf("R%0d", v[3:0]), rd_data == exp && rd_valid == v[55],
            {rd_valid, rd_data}, {v[55], exp});
    end

    // R2 / R10: idle edges drop valid and keep data
    set_cfg(1'b1, 9'h0A3, 16'h1234, 8'h5A);
    read_one(9'h0A3);
    held = rd_data;
    @(negedge clk);
    check("R2", rd_valid == 1'b0, {8'h00, rd_valid}, 9'h000);
    rd_addr = 9'h0A4;
    @(negedge clk);
    check("R10", rd_data == held, {1'b0, rd_data}, {1'b0, held});

    // R2 back-to-back strobes
    @(negedge clk);
    rd_strobe = 1'b1; rd_addr = 9'h0A3;
    @(negedge clk);
    check("R2", rd_valid && rd_data == 8'h12, {rd_valid, rd_data}, 9'h112);
    rd_addr = 9'h0A4;
    @(negedge clk);
    check("R2", rd_valid && rd_data == 8'h34, {rd_valid, rd_data}, 9'h134);
    rd_addr = 9'h0FF;
    @(negedge clk);
    check("R6", rd_valid && rd_data == 8'h5A, {rd_valid, rd_data}, 9'h15A);
    rd_strobe = 1'b0;

    // R8 disabled read after enabled data: forced to 0xFF
    set_cfg(1'b0, 9'h0A3, 16'h1234, 8'h5A);
    read_one(9'h020);
    check("R8", !rd_valid && rd_data == 8'hFF, {rd_valid, rd_data}, 9'h0FF);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", rd_valid == 1'b0 && rd_data == 8'hFF, {rd_valid, rd_data}, 9'h0FF);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule